// File: doc/BRIEF.md
# SDRAM Bank and Power-Mode Tracker

This block watches the command bus of a four-bank synchronous DRAM and keeps a cycle-accurate copy of the device's own view of its state. On every rising clock edge it samples chip select, the three command strobes, clock enable, the bank address and the row/column address. It records which banks hold an open row and which row that is, and it follows the device through normal operation, both power-down flavours and self refresh.

Mode-register writes are reported as a one-cycle event that carries the register selector and the opcode. Illegal sequences raise one-cycle error pulses. These cover activating an open bank, accessing a closed bank, self-refresh entry with a row still open, and clock enable dropping while a read or write burst is under way. A controller or a monitor on the same bus can use the outputs to cross-check its own bookkeeping.

Self-refresh exit is not tied to a sampled clock edge. A rising clock enable is passed through a two-flop synchroniser, so the return to normal mode lands on the third clock edge after the rise. All other clock-enable decisions are taken on the sampled edge.

Top module: `sdram_state_tracker`

## Requirements
- R1: After reset every bank is closed, `pwr_mode` is 0 (normal), and `err_seq`, `err_cke` and `mrs_valid` are low.
- R2: A cycle with `cs_n` sampled high changes no bank state and raises no event.
- R3: An activate ({ras_n,cas_n,we_n}=011, `cs_n` low) to a closed bank opens bank `ba` and records `addr` as its row. The result is visible after that edge.
- R4: A precharge (010) with `addr[8]`=0 closes only bank `ba`. With `addr[8]`=1 it closes all four banks.
- R5: An activate to an open bank, or a read (101) or write (100) to a closed bank, raises `err_seq` for one cycle and leaves every bank unchanged.
- R6: A mode-register set (000) raises `mrs_valid` for the cycle after the edge. In that cycle `mrs_ext` equals `ba[0]` and `mrs_opcode` equals `addr`.
- R7: In normal mode, `cke` sampled low without a refresh command enters precharge power-down (`pwr_mode`=1) if all banks are idle, and active power-down (2) otherwise. `cke` sampled high returns to normal (0). Commands sampled in power-down, including on the exit edge, are ignored.
- R8: A refresh command (001) with `cke` sampled low enters self refresh (3) when all banks are idle. With any bank open it enters active power-down and raises `err_seq` instead.
- R9: In self refresh, commands are ignored. A rise of `cke` is synchronised through two flops, and `pwr_mode` returns to 0 on the third rising clock edge after the rise.
- R10: `cke` sampled low in normal mode on any of the 4 edges that follow an accepted read or write raises `err_cke` for one cycle. On later edges it does not.
- R11: No-operation (111), burst stop (110) and refresh (001) with `cke` high change no bank state and raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable from the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row/column address and opcode |
| bank_open | output | 4 | One bit per bank, high when a row is open |
| open_rows | output | 48 | Recorded row per bank, bank n at bits [12n+11:12n] |
| pwr_mode | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 self refresh |
| mrs_valid | output | 1 | One-cycle mode-register write event |
| mrs_ext | output | 1 | High when the extended mode register was written |
| mrs_opcode | output | 12 | Opcode of the last mode-register write |
| err_seq | output | 1 | One-cycle illegal bank-sequence pulse |
| err_cke | output | 1 | One-cycle clock-enable-during-access pulse |

## Verification
A wrong bank bit is visible on `bank_open` in the very cycle after the faulty edge. It then changes the power-down flavour chosen at the next `cke` drop, and it changes which later activate or access raises `err_seq`. The bench therefore compares every output after every edge of full sweeps over all command codes, banks and precharge-all settings. A faulty synchroniser depth or access window shows only as a `pwr_mode` change or an `err_cke` pulse one edge early or late. The boundary edges of both windows are checked explicitly.

// File: rtl/sdtrk_pkg.sv
package sdtrk_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL, CMD_NOP, CMD_BST, CMD_ACT, CMD_RD,
    CMD_WR, CMD_PRE, CMD_REF, CMD_MRS
  } cmd_e;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'd0,
    PM_PPD    = 2'd1,
    PM_APD    = 2'd2,
    PM_SREF   = 2'd3
  } pmode_e;

  // Map the sampled strobes onto a command.
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    if (cs_n) return CMD_DESEL;
    case ({ras_n, cas_n, we_n})
      3'b111:  return CMD_NOP;
      3'b110:  return CMD_BST;
      3'b101:  return CMD_RD;
      3'b100:  return CMD_WR;
      3'b011:  return CMD_ACT;
      3'b010:  return CMD_PRE;
      3'b001:  return CMD_REF;
      default: return CMD_MRS;
    endcase
  endfunction

  // True when a precharge reaches a bank: either all-banks, or a matching index.
  function automatic logic pre_hits(input logic all_banks, input logic sel_match);
    return all_banks | sel_match;
  endfunction

  // True when the command is a column access.
  function automatic logic is_access(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/sdtrk_bank_table.sv
module sdtrk_bank_table
  import sdtrk_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 12,
  parameter int AP_BIT = 8,
  localparam int BA_W  = $clog2(NBANK)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     exec_en,
  input  cmd_e                     cmd,
  input  logic [BA_W-1:0]          ba,
  input  logic [ROW_W-1:0]         addr,
  output logic [NBANK-1:0]         bank_open,
  output logic [NBANK*ROW_W-1:0]   open_rows,
  output logic                     seq_err_evt,
  output logic                     acc_ok_evt
);

  logic tgt_open;
  logic do_act;
  logic do_pre;

  assign tgt_open    = bank_open[ba];
  assign do_act      = exec_en && (cmd == CMD_ACT) && !tgt_open;
  assign do_pre      = exec_en && (cmd == CMD_PRE);
  assign seq_err_evt = exec_en && (((cmd == CMD_ACT) && tgt_open) ||
                                   (is_access(cmd) && !tgt_open));
  assign acc_ok_evt  = exec_en && is_access(cmd) && tgt_open;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic sel;
    assign sel = (ba == BA_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_open[g]                 <= 1'b0;
        open_rows[g*ROW_W +: ROW_W]  <= '0;
      end else if (do_act && sel) begin
        bank_open[g]                 <= 1'b1;
        open_rows[g*ROW_W +: ROW_W]  <= addr;
      end else if (do_pre && pre_hits(addr[AP_BIT], sel)) begin
        bank_open[g]                 <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdtrk_access_window.sv
module sdtrk_access_window #(
  parameter int BURST_CYC = 4,
  localparam int CNT_W    = $clog2(BURST_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic acc_active
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= CNT_W'(BURST_CYC);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign acc_active = (cnt_q != '0);

endmodule

// File: rtl/sdtrk_power_ctrl.sv
module sdtrk_power_ctrl
  import sdtrk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cke,
  input  cmd_e   cmd,
  input  logic   any_open,
  input  logic   acc_active,
  output pmode_e mode,
  output logic   exec_en,
  output logic   ref_err_evt,
  output logic   cke_err_evt
);

  pmode_e mode_q, mode_d;
  logic   wake_s1, wake_s2;
  logic   in_sref;

  assign in_sref     = (mode_q == PM_SREF);
  assign exec_en     = (mode_q == PM_NORMAL) && cke;
  assign ref_err_evt = (mode_q == PM_NORMAL) && !cke && (cmd == CMD_REF) && any_open;
  assign cke_err_evt = (mode_q == PM_NORMAL) && !cke && acc_active;
  assign mode        = mode_q;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      PM_NORMAL: if (!cke) begin
        if ((cmd == CMD_REF) && !any_open) mode_d = PM_SREF;
        else if (any_open)                 mode_d = PM_APD;
        else                               mode_d = PM_PPD;
      end
      PM_PPD, PM_APD: if (cke) mode_d = PM_NORMAL;
      default:        if (wake_s2) mode_d = PM_NORMAL;
    endcase
  end

  // The chain only runs in self refresh, so stale highs cannot cause a false exit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= PM_NORMAL;
      wake_s1 <= 1'b0;
      wake_s2 <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      wake_s1 <= in_sref & cke;
      wake_s2 <= in_sref & wake_s1;
    end
  end

endmodule

// File: rtl/sdram_state_tracker.sv
module sdram_state_tracker
  import sdtrk_pkg::*;
#(
  parameter int NBANK     = 4,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 8,
  parameter int BURST_CYC = 4,
  localparam int BA_W     = $clog2(NBANK)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic [BA_W-1:0]         ba,
  input  logic [ADDR_W-1:0]       addr,
  output logic [NBANK-1:0]        bank_open,
  output logic [NBANK*ADDR_W-1:0] open_rows,
  output logic [1:0]              pwr_mode,
  output logic                    mrs_valid,
  output logic                    mrs_ext,
  output logic [ADDR_W-1:0]       mrs_opcode,
  output logic                    err_seq,
  output logic                    err_cke
);

  cmd_e   cmd;
  pmode_e mode;
  logic   exec_en;
  logic   seq_err_evt, acc_ok_evt, ref_err_evt, cke_err_evt;
  logic   acc_active;
  logic   mrs_evt;

  assign cmd     = decode_cmd(cs_n, ras_n, cas_n, we_n);
  assign mrs_evt = exec_en && (cmd == CMD_MRS);

  sdtrk_bank_table #(.NBANK(NBANK), .ROW_W(ADDR_W), .AP_BIT(AP_BIT)) u_banks (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .cmd(cmd), .ba(ba), .addr(addr),
    .bank_open(bank_open), .open_rows(open_rows),
    .seq_err_evt(seq_err_evt), .acc_ok_evt(acc_ok_evt)
  );

  sdtrk_access_window #(.BURST_CYC(BURST_CYC)) u_window (
    .clk(clk), .rst_n(rst_n), .start(acc_ok_evt), .acc_active(acc_active)
  );

  sdtrk_power_ctrl u_power (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .any_open(|bank_open),
    .acc_active(acc_active), .mode(mode), .exec_en(exec_en),
    .ref_err_evt(ref_err_evt), .cke_err_evt(cke_err_evt)
  );

  assign pwr_mode = mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrs_valid  <= 1'b0;
      mrs_ext    <= 1'b0;
      mrs_opcode <= '0;
      err_seq    <= 1'b0;
      err_cke    <= 1'b0;
    end else begin
      mrs_valid <= mrs_evt;
      err_seq   <= seq_err_evt | ref_err_evt;
      err_cke   <= cke_err_evt;
      if (mrs_evt) begin
        mrs_ext    <= ba[0];
        mrs_opcode <= addr;
      end
    end
  end

endmodule

// File: rtl/sdtrk_checker.sv
module sdtrk_checker #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             cs_n,
  input logic [NBANK-1:0] bank_open,
  input logic [1:0]       pwr_mode,
  input logic             mrs_valid,
  input logic             err_seq,
  input logic             err_cke,
  input logic             exec_en,
  input logic             acc_active
);

  AST_DESEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && cs_n) |=> $stable(bank_open)); // R2

  AST_SEQ_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    err_seq |-> $stable(bank_open)); // R5

  AST_MRS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_valid |-> ($past(exec_en) && !$past(cs_n))); // R6

  AST_PPD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd1) |-> (bank_open == '0)); // R7

  AST_APD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd2) |-> (bank_open != '0)); // R7

  AST_PD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 2'd0) |=> $stable(bank_open)); // R7

  AST_SREF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd3) |-> (bank_open == '0)); // R8

  AST_SREF_EXIT_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd3) |=> (pwr_mode == 2'd3 || pwr_mode == 2'd0)); // R9

  AST_CKE_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_cke |-> (!$past(cke) && $past(acc_active))); // R10

endmodule

bind sdram_state_tracker sdtrk_checker #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .bank_open(bank_open),
  .pwr_mode(pwr_mode), .mrs_valid(mrs_valid), .err_seq(err_seq),
  .err_cke(err_cke), .exec_en(exec_en), .acc_active(acc_active)
);

// File: tb/tb_sdram_state_tracker.sv
module tb_sdram_state_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [3:0]  bank_open;
  logic [47:0] open_rows;
  logic [1:0]  pwr_mode;
  logic        mrs_valid, mrs_ext, err_seq, err_cke;
  logic [11:0] mrs_opcode;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // Bench model of the bank state (normal mode only)
  logic [3:0]  m_open = '0;
  logic [11:0] m_row [4] = '{default: '0};

  always #2 clk = ~clk;

  sdram_state_tracker dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .bank_open(bank_open), .open_rows(open_rows),
    .pwr_mode(pwr_mode), .mrs_valid(mrs_valid), .mrs_ext(mrs_ext),
    .mrs_opcode(mrs_opcode), .err_seq(err_seq), .err_cke(err_cke)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic r, input logic a, input logic w,
                       input logic k, input logic [1:0] b, input logic [11:0] ad);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = a; we_n = w; cke = k; ba = b; addr = ad;
    @(posedge clk);
    #1;
  endtask

  // Normal-mode command with cke high, checked against the bench model.
  task automatic step(input logic c, input logic [2:0] code,
                      input logic [1:0] b, input logic [11:0] ad);
    logic  e_seq, e_mrs;
    string req;
    e_seq = 1'b0; e_mrs = 1'b0;
    drive(c, code[2], code[1], code[0], 1'b1, b, ad);
    if (c) req = "R2";
    else case (code)
      3'b011: begin
        req = "R3";
        if (m_open[b]) begin e_seq = 1'b1; req = "R5"; end
        else begin m_open[b] = 1'b1; m_row[b] = ad; end
      end
      3'b101, 3'b100: begin
        req = "R5";
        if (!m_open[b]) e_seq = 1'b1;
      end
      3'b010: begin
        req = "R4";
        if (ad[8]) m_open = '0; else m_open[b] = 1'b0;
      end
      3'b000: begin req = "R6"; e_mrs = 1'b1; end
      default: req = "R11";
    endcase
    check(req, "bank_open", 64'(bank_open), 64'(m_open));
    for (int i = 0; i < 4; i++)
      check(req, "row", 64'(open_rows[i*12 +: 12]), 64'(m_row[i]));
    check(req, "err_seq", 64'(err_seq), 64'(e_seq));
    check(req, "mrs_valid", 64'(mrs_valid), 64'(e_mrs));
    if (e_mrs) begin
      check("R6", "mrs_ext", 64'(mrs_ext), 64'(b[0]));
      check("R6", "mrs_opcode", 64'(mrs_opcode), 64'(ad));
    end
  endtask

  task automatic sweep(input int salt);
    for (int c = 0; c < 8; c++)
      for (int b = 0; b < 4; b++)
        for (int a8 = 0; a8 < 2; a8++) begin
          logic [11:0] ad;
          ad = {3'(c + salt), 1'(a8), 2'(b), 6'(c * 5 + b + salt)};
          step(((c + b + a8 + salt) % 5) == 0, 3'(c), 2'(b), ad);
        end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "bank_open", 64'(bank_open), 64'h0);
    check("R1", "pwr_mode", 64'(pwr_mode), 64'h0);
    check("R1", "events", 64'({err_seq, err_cke, mrs_valid}), 64'h0);

    sweep(0);
    sweep(3);

    // Directed: precharge-all, then precharge power-down
    step(1'b0, 3'b010, 2'd1, 12'h100);
    check("R4", "all closed", 64'(bank_open), 64'h0);
    drive(0, 1, 1, 1, 0, 2'd0, 12'h0);
    check("R7", "ppd entry", 64'(pwr_mode), 64'd1);
    drive(0, 0, 1, 1, 0, 2'd2, 12'h3C3);
    check("R7", "act ignored in pd", 64'(bank_open), 64'h0);
    drive(0, 0, 1, 1, 1, 2'd2, 12'h3C3);
    check("R7", "pd exit", 64'(pwr_mode), 64'd0);
    check("R7", "exit-edge cmd ignored", 64'(bank_open), 64'h0);

    // Active power-down
    step(1'b0, 3'b011, 2'd2, 12'h2A5);
    drive(0, 1, 1, 1, 0, 2'd0, 12'h0);
    check("R7", "apd entry", 64'(pwr_mode), 64'd2);
    drive(1, 1, 1, 1, 1, 2'd0, 12'h0);
    check("R7", "apd exit", 64'(pwr_mode), 64'd0);

    // Refresh with cke low and a bank open
    drive(0, 0, 0, 1, 0, 2'd0, 12'h0);
    check("R8", "refresh open -> apd", 64'(pwr_mode), 64'd2);
    check("R8", "refresh open err", 64'(err_seq), 64'd1);
    drive(1, 1, 1, 1, 1, 2'd0, 12'h0);
    check("R8", "exit", 64'(pwr_mode), 64'd0);
    step(1'b0, 3'b010, 2'd0, 12'h100);

    // Self refresh entry from idle
    drive(0, 0, 0, 1, 0, 2'd0, 12'h0);
    check("R8", "sref entry", 64'(pwr_mode), 64'd3);
    check("R8", "no err", 64'(err_seq), 64'd0);
    drive(1, 1, 1, 1, 0, 2'd0, 12'h0);
    drive(0, 0, 1, 1, 0, 2'd1, 12'h055);
    check("R9", "sref hold", 64'(pwr_mode), 64'd3);
    check("R9", "act ignored in sref", 64'(bank_open), 64'h0);

    // Asynchronous exit through the synchroniser: normal on the third edge
    drive(0, 0, 1, 1, 1, 2'd1, 12'h055);
    check("R9", "edge1 still sref", 64'(pwr_mode), 64'd3);
    drive(0, 0, 1, 1, 1, 2'd1, 12'h055);
    check("R9", "edge2 still sref", 64'(pwr_mode), 64'd3);
    drive(1, 1, 1, 1, 1, 2'd0, 12'h0);
    check("R9", "edge3 normal", 64'(pwr_mode), 64'd0);
    check("R9", "no bank opened", 64'(bank_open), 64'h0);

    // cke drop one edge after a write
    step(1'b0, 3'b011, 2'd0, 12'h011);
    step(1'b0, 3'b100, 2'd0, 12'h000);
    drive(1, 1, 1, 1, 0, 2'd0, 12'h0);
    check("R10", "cke drop in write", 64'(err_cke), 64'd1);
    check("R10", "apd", 64'(pwr_mode), 64'd2);
    drive(1, 1, 1, 1, 1, 2'd0, 12'h0);
    check("R10", "pulse ends", 64'(err_cke), 64'd0);

    // cke drop on the fifth edge after a read: outside the window
    step(1'b0, 3'b101, 2'd0, 12'h000);
    for (int i = 0; i < 4; i++) step(1'b0, 3'b111, 2'd0, 12'h0);
    drive(1, 1, 1, 1, 0, 2'd0, 12'h0);
    check("R10", "after window", 64'(err_cke), 64'd0);
    drive(1, 1, 1, 1, 1, 2'd0, 12'h0);

    // cke drop on the fourth edge after a read: last edge inside
    step(1'b0, 3'b101, 2'd0, 12'h000);
    for (int i = 0; i < 3; i++) step(1'b0, 3'b111, 2'd0, 12'h0);
    drive(1, 1, 1, 1, 0, 2'd0, 12'h0);
    check("R10", "last window edge", 64'(err_cke), 64'd1);
    drive(1, 1, 1, 1, 1, 2'd0, 12'h0);

    sweep(6);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule